// File: doc/BRIEF.md
# Protected Low-Memory Window Lock

This block is a single byte-wide configuration register together with an address filter on a host-to-memory byte path. Out of reset the register reads 0 and the fixed window of low memory starting at the window base acts as ordinary RAM. Software can enable protection only through a two-step exchange. A write of 0xFF arms the feature. A later write of 0x02 locks it. Every other write is refused. After the lock, the register cannot change and the window turns into a sink: its reads return 0xFF and its writes never reach memory. Only a system reset undoes this. The memory behind the block is not cleared by that reset.

The block sits between a host byte port and the memory. Accesses outside the window pass through untouched. When the compatibility parameter is set, the register is a plain stored byte and the window is never filtered.

Top module: `smram_window_guard`

## Requirements
- R1: After reset the register reads 0x00 at configuration offset 0x9C, and a byte written inside the window reads back unchanged.
- R2: While unarmed, a write of any value 0x00 to 0xFE leaves the register reading 0x00.
- R3: While unarmed, a write of 0xFF arms the feature, and the register then reads 0x01.
- R4: While armed, a write of any value other than 0x02 leaves the register at 0x01. A write of 0x02 locks the feature, and the register then reads 0x02.
- R5: Once locked, a write of any value 0x00 to 0xFF leaves the register reading 0x02.
- R6: Once locked, a read inside the window (base 0x30000, default size 0x20000 bytes) returns 0xFF and issues no memory request.
- R7: Once locked, a write inside the window issues no memory request, so the memory contents are unchanged.
- R8: Accesses outside the window (0x2FFFF, 0x50000) always pass through, in every state.
- R9: Reset returns the register to 0x00 and restores the window, and data written before the lock is visible again.
- R10: With the compatibility parameter set, the register stores and returns any written byte and the window stays plain RAM.
- R11: Only configuration offset 0x9C is decoded. A write to any other offset has no effect, and a read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| host_req | input | 1 | Host memory access valid |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench sweeps every byte value through the unarmed, armed and locked states. A design that accepted a stray value would drift to the wrong readback code, and one that let 0xFF re-arm, or that unlocked from a locked state, would show 0x01 or 0x00 where 0x02 is due. After each locked sweep step the bench writes into the window and reads it back. A leaky filter would return the written pattern instead of 0xFF, and it would also corrupt the byte that reappears after reset. The bench probes both window edges to catch an off-by-one in the range compare. It uses a second register offset to catch loose decoding, and it runs the full byte sweep on the compatibility instance.

// File: rtl/smram_window_guard.sv
module smram_window_guard #(
  parameter bit              LEGACY    = 1'b0,
  parameter int              ADDR_W    = 20,
  parameter longint unsigned WIN_BASE  = 64'h30000,
  parameter longint unsigned WIN_BYTES = 64'h20000,
  parameter logic [7:0]      CFG_OFF   = 8'h9C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam logic [63:0] WIN_LO  = 64'(WIN_BASE);
  localparam logic [63:0] WIN_HI  = 64'(WIN_BASE) + 64'(WIN_BYTES);
  localparam logic [7:0]  ARM_KEY = 8'hFF;
  localparam logic [7:0]  LCK_KEY = 8'h02;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ARMED = 2'd1, ST_LOCKED = 2'd2} lock_t;

  logic        hit_wr;
  logic        in_win;
  logic        blocked;
  logic [7:0]  reg_view;
  logic [63:0] addr64;

  assign hit_wr = cfg_we && (cfg_addr == CFG_OFF);
  assign addr64 = 64'(host_addr);
  assign in_win = (addr64 >= WIN_LO) && (addr64 < WIN_HI);

  generate
    if (LEGACY) begin : g_plain
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      byte_q <= 8'h00;
        else if (hit_wr) byte_q <= cfg_wdata;
      end
      assign reg_view = byte_q;
      assign blocked  = 1'b0;

      a_r10_stores_byte: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr |=> (cfg_rdata == $past(cfg_wdata) || cfg_addr != CFG_OFF));
    end else begin : g_lock
      lock_t st_q, st_d;
      always_comb begin
        st_d = st_q;
        if (hit_wr) begin
          unique case (st_q)
            ST_IDLE:   if (cfg_wdata == ARM_KEY) st_d = ST_ARMED;
            ST_ARMED:  if (cfg_wdata == LCK_KEY) st_d = ST_LOCKED;
            default:   st_d = st_q;
          endcase
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
      end
      assign reg_view = {6'b0, st_q};
      assign blocked  = (st_q == ST_LOCKED) && in_win;

      a_r2_idle_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && hit_wr && cfg_wdata != ARM_KEY) |=> st_q == ST_IDLE);
      a_r3_arm_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && hit_wr && cfg_wdata == ARM_KEY) |=> st_q == ST_ARMED);
      a_r4_lock_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && hit_wr && cfg_wdata == LCK_KEY) |=> st_q == ST_LOCKED);
      a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCKED) |=> st_q == ST_LOCKED);
      a_r6_sink_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCKED && host_req && in_win) |-> (host_rdata == 8'hFF && !mem_req));
      a_r7_no_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCKED && host_req && host_we && in_win) |-> !mem_we);
    end
  endgenerate

  assign cfg_rdata  = (cfg_addr == CFG_OFF) ? reg_view : 8'h00;
  assign mem_req    = host_req && !blocked;
  assign mem_we     = host_req && host_we && !blocked;
  assign mem_addr   = host_addr;
  assign mem_wdata  = host_wdata;
  assign host_rdata = blocked ? 8'hFF : mem_rdata;

  a_r8_outside_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !in_win) |-> (mem_req && host_rdata == mem_rdata));
endmodule

// File: tb/sim_smram_window_guard.sv
module sim_smram_window_guard;
  localparam int CLK_NS = 10;
  localparam int AW = 20;
  localparam logic [7:0] OFF = 8'h9C;
  localparam logic [AW-1:0] BASE = 20'h30000;
  localparam logic [AW-1:0] BELOW = 20'h2FFFF;
  localparam logic [AW-1:0] LAST = 20'h4FFFF;
  localparam logic [AW-1:0] BEYOND = 20'h50000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [7:0] cfg_addr = OFF, cfg_wdata = 8'h00;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0; logic [7:0] host_wdata = 8'h00;
  logic [7:0] cfg_rd0, cfg_rd1, hr0, hr1, mrd0, mrd1, mwd0, mwd1;
  logic mreq0, mreq1, mwe0, mwe1;
  logic [AW-1:0] ma0, ma1;
  logic [7:0] ram0 [32];
  logic [7:0] ram1 [32];
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  smram_window_guard #(.LEGACY(1'b0), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rd0), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(hr0), .mem_req(mreq0), .mem_we(mwe0),
    .mem_addr(ma0), .mem_wdata(mwd0), .mem_rdata(mrd0));

  smram_window_guard #(.LEGACY(1'b1), .ADDR_W(AW)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rd1), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(hr1), .mem_req(mreq1), .mem_we(mwe1),
    .mem_addr(ma1), .mem_wdata(mwd1), .mem_rdata(mrd1));

  function automatic logic [4:0] slot(input logic [AW-1:0] a);
    return {a[18:16], a[1:0]};
  endfunction

  initial for (int k = 0; k < 32; k++) begin ram0[k] = 8'h00; ram1[k] = 8'h00; end
  always @(posedge clk) begin
    if (mreq0 && mwe0) ram0[slot(ma0)] <= mwd0;
    if (mreq1 && mwe1) ram1[slot(ma1)] <= mwd1;
  end
  assign mrd0 = ram0[slot(ma0)];
  assign mrd1 = ram1[slot(ma1)];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_addr = OFF;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [7:0] v0, output logic [7:0] v1);
    cfg_addr = a; #1; v0 = cfg_rd0; v1 = cfg_rd1; cfg_addr = OFF;
  endtask

  task automatic mem_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [AW-1:0] a, output logic [7:0] v0, output logic [7:0] v1,
                        output logic rq0);
    @(negedge clk); host_req = 1'b1; host_we = 1'b0; host_addr = a;
    #1; v0 = hr0; v1 = hr1; rq0 = mreq0;
    @(negedge clk); host_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic edges(input logic [7:0] pat, input string tag);
    logic [7:0] a0, a1; logic rq;
    mem_wr(BELOW, pat); mem_rd(BELOW, a0, a1, rq);
    chk(a0 == pat, tag, a0, pat);
    mem_wr(BEYOND, pat ^ 8'h5A); mem_rd(BEYOND, a0, a1, rq);
    chk(a0 == (pat ^ 8'h5A), tag, a0, pat ^ 8'h5A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r0, r1, d0, d1; logic rq;
    repeat (2) @(negedge clk); rst_n = 1'b1;

    // R1 reset state and plain RAM in the window
    cfg_rd(OFF, r0, r1); chk(r0 == 8'h00, "R1 reg after reset", r0, 0);
    mem_wr(BASE, 8'h32); mem_rd(BASE, d0, d1, rq); chk(d0 == 8'h32, "R1 window RAM", d0, 8'h32);
    mem_wr(LAST, 8'h44); mem_rd(LAST, d0, d1, rq); chk(d0 == 8'h44, "R1 window last byte", d0, 8'h44);
    edges(8'h11, "R8 outside idle");

    // R11 other offsets ignored
    cfg_wr(8'h9D, 8'hFF); cfg_rd(OFF, r0, r1); chk(r0 == 8'h00, "R11 wrong offset write", r0, 0);
    cfg_rd(8'h9D, r0, r1); chk(r0 == 8'h00, "R11 wrong offset read", r0, 0);

    // R2 idle sweep
    for (int i = 0; i < 255; i++) begin
      cfg_wr(OFF, 8'(i)); cfg_rd(OFF, r0, r1);
      chk(r0 == 8'h00, "R2 idle ignores", r0, 0);
    end
    // R3 arm
    cfg_wr(OFF, 8'hFF); cfg_rd(OFF, r0, r1); chk(r0 == 8'h01, "R3 armed readback", r0, 1);
    mem_rd(BASE, d0, d1, rq); chk(d0 == 8'h32, "R3 armed window still RAM", d0, 8'h32);
    // R4 armed sweep
    for (int i = 0; i < 256; i++) begin
      if (i != 2) begin
        cfg_wr(OFF, 8'(i)); cfg_rd(OFF, r0, r1);
        chk(r0 == 8'h01, "R4 armed ignores", r0, 1);
      end
    end
    cfg_wr(OFF, 8'h02); cfg_rd(OFF, r0, r1); chk(r0 == 8'h02, "R4 locked readback", r0, 2);

    // R5 R6 R7 locked sweep
    mem_rd(BASE, d0, d1, rq); chk(d0 == 8'hFF, "R6 locked read", d0, 8'hFF);
    chk(rq == 1'b0, "R6 no mem request", rq, 0);
    mem_rd(LAST, d0, d1, rq); chk(d0 == 8'hFF, "R6 locked last byte", d0, 8'hFF);
    for (int i = 0; i < 256; i++) begin
      cfg_wr(OFF, 8'(i)); cfg_rd(OFF, r0, r1);
      chk(r0 == 8'h02, "R5 locked immutable", r0, 2);
      mem_wr(BASE, 8'(i)); mem_rd(BASE, d0, d1, rq);
      chk(d0 == 8'hFF, "R7 locked write discarded", d0, 8'hFF);
    end
    edges(8'h66, "R8 outside locked");

    // R9 reset restores
    do_reset();
    cfg_rd(OFF, r0, r1); chk(r0 == 8'h00, "R9 reg after reset", r0, 0);
    mem_rd(BASE, d0, d1, rq); chk(d0 == 8'h32, "R9 earlier data visible", d0, 8'h32);
    mem_rd(LAST, d0, d1, rq); chk(d0 == 8'h44, "R9 earlier last byte", d0, 8'h44);
    mem_wr(BASE, 8'h23); mem_rd(BASE, d0, d1, rq); chk(d0 == 8'h23, "R9 window writable", d0, 8'h23);
    cfg_wr(OFF, 8'h02); cfg_rd(OFF, r0, r1); chk(r0 == 8'h00, "R2 lock key unarmed", r0, 0);

    // R10 compatibility instance
    for (int i = 0; i < 256; i++) begin
      cfg_wr(OFF, 8'(i)); cfg_rd(OFF, r0, r1);
      chk(r1 == 8'(i), "R10 legacy stores byte", r1, i);
    end
    cfg_wr(OFF, 8'hFF); cfg_wr(OFF, 8'h02);
    mem_wr(BASE, 8'h77); mem_rd(BASE, d0, d1, rq);
    chk(d1 == 8'h77, "R10 legacy window RAM", d1, 8'h77);
    cfg_wr(8'h9D, 8'hAB); cfg_rd(OFF, r0, r1); chk(r1 == 8'h02, "R11 legacy wrong offset", r1, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule